// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is an I2C bus master that software runs one byte at a time through four byte-wide registers. Software loads the data register and then writes the status register. That write either opens a transfer with a START or, while a transfer is already open, arms a repeated START or a STOP. The block then sends the loaded byte as the address.

After every byte and its acknowledge clock, the block raises a pending flag and parks the bus with SCL held low. Clearing that flag launches the next action: the next byte in the selected direction, the armed repeated START, or the armed STOP.

The bit rate comes from a coarse prescale of 16 or 512 followed by a 4-bit divider. An interrupt line mirrors the pending flag when it is enabled. Both bus lines are modelled as open-drain drive-low enables, and SDA is also sampled back as an input.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register (offset 0) and the status register (offset 1) read 0x00, irq is low, and neither bus line is driven low.
- R2: From idle, a status write with mode bits [7:6] set to 2'b11 (transmit) or 2'b10 (receive), enable bit [4] and start bit [5] pulls SDA low while SCL is high. It then shifts out the data register (offset 3), MSB first, as the address byte. From that write until the STOP, status bit [5] reads 1 (busy).
- R3: Within a byte, consecutive SCL rising edges are P*(N+1) clock cycles apart. N is control bits [3:0]. P is 16 when control bit [6] is 0 and 512 when it is 1.
- R4: After the ninth clock of every byte, control bit [4] (pending) reads 1 and SCL stays low with no further bus edges. This lasts until software writes the control register with bit [4] at 0. Writing bit [4] as 1 never sets the flag and never clears it.
- R5: irq is high exactly while pending is set and control bit [5] is 1.
- R6: In transmit mode, each pending clear sends the data register. Status bit [0] then holds the SDA level sampled on the acknowledge clock of the last transmitted byte (1 = not acknowledged).
- R7: In receive mode, each pending clear clocks in one byte, which the data register holds once pending sets. On that byte's ninth clock the block drives SDA low (ACK) when control bit [7] is 1 and leaves SDA released (NACK) when it is 0.
- R8: While busy, a status write carrying start, enable and a master mode, followed by a pending clear, releases SDA and then SCL. It then pulls SDA low while SCL is high, with no STOP in between, and sends the data register as the new address byte.
- R9: While busy, a status write with start bit [5] at 0, followed by a pending clear, releases SCL and then releases SDA while SCL is high (STOP). Busy then reads 0.
- R10: A start request whose enable bit [4] or mode bit [7] is 0 is ignored: busy stays 0 and both lines stay released.
- R11: Offset 2 stores a 7-bit own-address value that reads back with bit [7] at 0.
- R12: SDA changes while SCL is high only to form a START, a repeated START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| irq | output | 1 | Interrupt request |
| sclDrvLow | output | 1 | Drive SCL low when 1 |
| sdaDrvLow | output | 1 | Drive SDA low when 1 |
| sdaIn | input | 1 | Sampled SDA line level |

## Verification
The bench sweeps every divider value at the low prescale and two values at the high prescale. A divider counted off by one, or prescale factors swapped, would show as a wrong rise-to-rise spacing. A bus-level slave model acknowledges, withholds acknowledge and returns a known byte stream. This exposes a master that drops the NACK status, acknowledges the final received byte, or inserts a STOP where a repeated START belongs. The bench also watches the parked bus for edges while pending is set, which catches a design that frees SCL before software clears the flag. Finally it tries start writes that lack enable or a master mode, which a careless decoder would act on.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DIV_W = 4;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CTL_PEND  = 4;
  localparam int CTL_IRQEN = 5;
  localparam int CTL_PRE   = 6;
  localparam int CTL_ACK   = 7;

  localparam int ST_NACK  = 0;
  localparam int ST_EN    = 4;
  localparam int ST_START = 5;

  localparam logic [1:0] MODE_RX = 2'b10;

  typedef enum logic [1:0] {CMD_NONE, CMD_RESTART, CMD_STOP} cmd_e;

  typedef struct packed {
    logic shiftIn;
    logic nackLatch;
    logic pendSet;
    logic busyClr;
    logic cmdClr;
  } strobe_t;
endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen
  import i2cm_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             preSel,
  input  logic [DIV_W-1:0] divVal,
  output logic             tick
);
  localparam int QLO = PRE_LO / 4;
  localparam int QHI = PRE_HI / 4;
  localparam int CW  = $clog2(QHI * (2 ** DIV_W)) + 1;

  logic [CW-1:0] quarter;
  logic [CW-1:0] span;
  logic [CW-1:0] cnt;

  assign quarter = preSel ? CW'(QHI) : CW'(QLO);
  assign span    = quarter * (CW'(divVal) + CW'(1));
  assign tick    = run && (cnt == span - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  strobe_t          strobe,
  input  logic             sdaIn,
  output logic [DIV_W-1:0] divVal,
  output logic             preSel,
  output logic             ackEn,
  output logic             pending,
  output logic             busy,
  output logic             irq,
  output logic             modeRx,
  output logic             dataMsb,
  output logic             launchStart,
  output logic             resume,
  output cmd_e             cmdKind
);
  logic       irqEn;
  logic       enable;
  logic       nack;
  logic [1:0] mode;
  logic [6:0] ownAddr;
  logic [7:0] dataReg;
  logic       ctrlWr;
  logic       statWr;
  logic       ownWr;
  logic       dataWr;
  logic       masterReq;

  assign ctrlWr    = regWe && (regAddr == REG_CTRL);
  assign statWr    = regWe && (regAddr == REG_STAT);
  assign ownWr     = regWe && (regAddr == REG_OWN);
  assign dataWr    = regWe && (regAddr == REG_DATA);
  assign masterReq = regWdata[ST_EN] && regWdata[7];

  assign launchStart = statWr && regWdata[ST_START] && masterReq && !busy;
  assign resume      = ctrlWr && !regWdata[CTL_PEND] && pending;
  assign irq         = pending && irqEn;
  assign modeRx      = (mode == MODE_RX);
  assign dataMsb     = dataReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divVal <= '0;
      irqEn  <= 1'b0;
      preSel <= 1'b0;
      ackEn  <= 1'b0;
    end else if (ctrlWr) begin
      divVal <= regWdata[DIV_W-1:0];
      irqEn  <= regWdata[CTL_IRQEN];
      preSel <= regWdata[CTL_PRE];
      ackEn  <= regWdata[CTL_ACK];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.pendSet) begin
      pending <= 1'b1;
    end else if (ctrlWr && !regWdata[CTL_PEND]) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= 2'b00;
      enable <= 1'b0;
    end else if (statWr) begin
      mode   <= regWdata[7:6];
      enable <= regWdata[ST_EN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (launchStart) begin
      busy <= 1'b1;
    end else if (strobe.busyClr) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdKind <= CMD_NONE;
    end else if (statWr && busy) begin
      cmdKind <= (regWdata[ST_START] && masterReq) ? CMD_RESTART : CMD_STOP;
    end else if (strobe.cmdClr) begin
      cmdKind <= CMD_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.shiftIn) begin
      dataReg <= {dataReg[6:0], sdaIn};
    end else if (dataWr) begin
      dataReg <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nack <= 1'b0;
    end else if (strobe.nackLatch) begin
      nack <= sdaIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0;
    end else if (ownWr) begin
      ownAddr <= regWdata[6:0];
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdata = {ackEn, preSel, irqEn, pending, divVal};
      REG_STAT: regRdata = {mode, busy, enable, 3'b000, nack};
      REG_OWN:  regRdata = {1'b0, ownAddr};
      default:  regRdata = dataReg;
    endcase
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    launchStart,
  input  logic    resume,
  input  cmd_e    cmdKind,
  input  logic    modeRx,
  input  logic    ackEn,
  input  logic    dataMsb,
  output strobe_t strobe,
  output logic    run,
  output logic    sclLow,
  output logic    sdaLow
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_STOP} state_e;

  localparam logic [3:0] ACK_SLOT = 4'd8;

  state_e     state;
  logic [1:0] step;
  logic [3:0] bitIdx;
  logic       addrByte;
  logic       txByte;
  logic       ackSlot;

  assign txByte  = addrByte || !modeRx;
  assign ackSlot = (bitIdx == ACK_SLOT);
  assign run     = (state == S_SETUP) || (state == S_SHIFT) || (state == S_STOP);

  always_comb begin
    strobe = '0;
    strobe.shiftIn   = (state == S_SHIFT) && tick && (step == 2'd2) && !ackSlot;
    strobe.nackLatch = (state == S_SHIFT) && tick && (step == 2'd2) && ackSlot && txByte;
    strobe.pendSet   = (state == S_SHIFT) && tick && (step == 2'd3) && ackSlot;
    strobe.busyClr   = (state == S_STOP) && tick && (step == 2'd3);
    strobe.cmdClr    = (state == S_HOLD) && resume;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      step     <= 2'd0;
      bitIdx   <= 4'd0;
      addrByte <= 1'b0;
      sclLow   <= 1'b0;
      sdaLow   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (launchStart) begin
            state    <= S_SETUP;
            step     <= 2'd2;
            addrByte <= 1'b1;
          end
        end
        S_SETUP: begin
          if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: sdaLow <= 1'b0;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b1;
              default: begin
                sclLow <= 1'b1;
                state  <= S_SHIFT;
                bitIdx <= 4'd0;
              end
            endcase
          end
        end
        S_SHIFT: begin
          if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: begin
                if (!ackSlot) sdaLow <= txByte ? !dataMsb : 1'b0;
                else          sdaLow <= txByte ? 1'b0 : ackEn;
              end
              2'd1: sclLow <= 1'b0;
              2'd2: ;
              default: begin
                sclLow <= 1'b1;
                if (ackSlot) begin
                  state    <= S_HOLD;
                  addrByte <= 1'b0;
                end else begin
                  bitIdx <= bitIdx + 4'd1;
                end
              end
            endcase
          end
        end
        S_HOLD: begin
          if (resume) begin
            step <= 2'd0;
            case (cmdKind)
              CMD_RESTART: begin
                state    <= S_SETUP;
                addrByte <= 1'b1;
              end
              CMD_STOP: state <= S_STOP;
              default: begin
                state  <= S_SHIFT;
                bitIdx <= 4'd0;
              end
            endcase
          end
        end
        S_STOP: begin
          if (tick) begin
            step <= step + 2'd1;
            case (step)
              2'd0: sdaLow <= 1'b1;
              2'd1: sclLow <= 1'b0;
              2'd2: sdaLow <= 1'b0;
              default: state <= S_IDLE;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  output logic       sclDrvLow,
  output logic       sdaDrvLow,
  input  logic       sdaIn
);
  strobe_t          strobe;
  logic [DIV_W-1:0] divVal;
  logic             preSel;
  logic             ackEn;
  logic             pending;
  logic             busy;
  logic             modeRx;
  logic             dataMsb;
  logic             launchStart;
  logic             resume;
  cmd_e             cmdKind;
  logic             run;
  logic             tick;

  i2cm_datapath dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe), .sdaIn(sdaIn),
    .divVal(divVal), .preSel(preSel), .ackEn(ackEn), .pending(pending),
    .busy(busy), .irq(irq), .modeRx(modeRx), .dataMsb(dataMsb),
    .launchStart(launchStart), .resume(resume), .cmdKind(cmdKind)
  );

  i2cm_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) cg (
    .clk(clk), .rstN(rstN), .run(run), .preSel(preSel), .divVal(divVal),
    .tick(tick)
  );

  i2cm_ctrl fsm (
    .clk(clk), .rstN(rstN), .tick(tick), .launchStart(launchStart),
    .resume(resume), .cmdKind(cmdKind), .modeRx(modeRx), .ackEn(ackEn),
    .dataMsb(dataMsb), .strobe(strobe), .run(run), .sclLow(sclDrvLow),
    .sdaLow(sdaDrvLow)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rstN,
  input logic sclDrvLow,
  input logic sdaDrvLow,
  input logic pending,
  input logic busy
);
  assert_hold_scl_R4: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> sclDrvLow);

  assert_hold_sda_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && $past(pending)) |-> $stable(sdaDrvLow));

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDrvLow && !sdaDrvLow));

  assert_start_released_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!sclDrvLow && !sdaDrvLow));

  assert_sda_high_scl_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!sclDrvLow && !$past(sclDrvLow) && $changed(sdaDrvLow)) |-> busy);
endmodule

bind i2c_byte_master i2cm_checker chk (
  .clk(clk), .rstN(rstN), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
  .pending(pending), .busy(busy)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       irq;
  logic       sclDrvLow;
  logic       sdaDrvLow;
  logic       slaveLow = 1'b0;
  logic       sdaIn;

  int total = 0;
  int fails = 0;

  assign sdaIn = !(sdaDrvLow || slaveLow);

  always #5 clk = ~clk;

  i2c_byte_master uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .sdaIn(sdaIn)
  );

  // bus monitor and slave model
  logic       slaveAck = 1'b1;
  logic [7:0] rdBase = 8'h96;
  int         cyc = 0, bitCnt = -1, starts = 0, stops = 0, rises = 0;
  int         nBytes = 0, lastRise = 0, period = 0, rxIdx = 0;
  logic       prevScl = 1'b1, prevSda = 1'b1, firstByte = 1'b0;
  logic       readMode = 1'b0, active = 1'b0, lastAck = 1'b1;
  logic [7:0] sh = 8'd0;
  logic [7:0] byteLog [0:63];
  logic       ackLog [0:63];

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    logic [7:0] r = v;
    for (int i = 0; i < n; i++) r = {r[6:0], r[7]};
    return r;
  endfunction

  always @(negedge clk) begin
    logic sclH, sda, wasFirst;
    logic [7:0] cur;
    cyc++;
    sclH = !sclDrvLow;
    sda  = sdaIn;
    if (sclH && prevScl && prevSda && !sda) begin
      starts++; bitCnt = -1; firstByte = 1'b1; active = 1'b1; rxIdx = 0; slaveLow = 1'b0;
    end else if (sclH && prevScl && !prevSda && sda) begin
      stops++;
    end else if (!prevScl && sclH) begin
      rises++;
      if (bitCnt >= 1) period = cyc - lastRise;
      lastRise = cyc;
      if (bitCnt < 8) sh = {sh[6:0], sda};
      else begin
        byteLog[nBytes] = sh; ackLog[nBytes] = sda; nBytes++; lastAck = sda;
      end
    end else if (prevScl && !sclH) begin
      if (bitCnt == 8) begin
        bitCnt = 0;
        wasFirst = firstByte;
        if (wasFirst) begin
          readMode = sh[0]; active = !lastAck; firstByte = 1'b0;
        end else if (readMode) begin
          rxIdx++;
          if (lastAck) active = 1'b0;
        end
      end else bitCnt++;
      slaveLow = 1'b0;
      cur = rotl(rdBase, rxIdx);
      if (bitCnt == 8 && (firstByte || (!readMode && active))) slaveLow = slaveAck;
      else if (!firstByte && readMode && active && bitCnt >= 0 && bitCnt < 8)
        slaveLow = !cur[7 - bitCnt];
    end
    prevScl = sclH;
    prevSda = sdaIn;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitPend(input string req);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, v);
      if (v[4]) return;
    end
    check({req, " pending timeout"}, 0, 1);
  endtask

  task automatic waitIdle(input string req);
    logic [7:0] v;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd1, v);
      if (!v[5]) return;
    end
    check({req, " busy timeout"}, 1, 0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [7:0] v;
    int idx, r0, s0, t0, pre;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 lines", {sclDrvLow, sdaDrvLow}, 0);

    // R4 writing pending as 1 does not set it
    wr(2'd0, 8'h10); rd(2'd0, v); check("R4 no self-set", v, 8'h00);

    // R11 own address
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R11 own", v, 8'h5A);
    wr(2'd2, 8'hFF); rd(2'd2, v); check("R11 own 7-bit", v, 8'h7F);

    // R10 start without enable or without master mode
    wr(2'd3, 8'hA4);
    wr(2'd1, 8'hE0);
    wr(2'd1, 8'h70);
    repeat (300) @(negedge clk);
    rd(2'd1, v); check("R10 busy", v[5], 0);
    check("R10 starts", starts, 0);
    check("R10 lines", {sclDrvLow, sdaDrvLow}, 0);

    // R2/R6 transmit transaction
    wr(2'd0, 8'hA0);
    idx = nBytes;
    wr(2'd1, 8'hF0);
    rd(2'd1, v); check("R2 busy", v, 8'hF0);
    waitPend("R2");
    check("R2 start", starts, 1);
    check("R2 addr byte", byteLog[idx], 8'hA4);
    check("R6 addr ack", ackLog[idx], 0);
    check("R5 irq on", irq, 1);
    r0 = rises;
    wr(2'd0, 8'hB0);
    repeat (200) @(negedge clk);
    rd(2'd0, v); check("R4 pend kept", v[4], 1);
    check("R4 no edges", rises, r0);
    check("R4 scl low", sclDrvLow, 1);
    wr(2'd3, 8'h3C); wr(2'd0, 8'hA0);
    rd(2'd0, v); check("R4 cleared", v[4], 0);
    check("R5 irq off", irq, 0);
    waitPend("R6");
    check("R6 data byte", byteLog[idx + 1], 8'h3C);
    check("R3 period 16", period, 16);
    rd(2'd1, v); check("R6 ack status", v[0], 0);
    slaveAck = 1'b0;
    wr(2'd3, 8'h81); wr(2'd0, 8'hA0);
    waitPend("R6");
    check("R6 data byte2", byteLog[idx + 2], 8'h81);
    rd(2'd1, v); check("R6 nack status", v[0], 1);
    slaveAck = 1'b1;
    wr(2'd1, 8'hD0); wr(2'd0, 8'hA0);
    waitIdle("R9");
    check("R9 stop", stops, 1);
    check("R9 lines", {sclDrvLow, sdaDrvLow}, 0);

    // R3 rate sweep
    for (int sel = 0; sel < 2; sel++) begin
      for (int n = 0; n < (sel ? 2 : 16); n++) begin
        pre = sel ? 512 : 16;
        wr(2'd0, 8'h80 | (sel ? 8'h40 : 8'h00) | 8'(n));
        wr(2'd3, 8'(n * 16 + 10));
        idx = nBytes;
        wr(2'd1, 8'hF0);
        waitPend("R3");
        check("R3 byte", byteLog[idx], n * 16 + 10);
        check("R3 period", period, pre * (n + 1));
        check("R5 irq masked", irq, 0);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h80 | (sel ? 8'h40 : 8'h00) | 8'(n));
        waitIdle("R9");
      end
    end

    // R7/R8 register write then repeated start read
    wr(2'd0, 8'hA0);
    wr(2'd3, 8'hA4);
    idx = nBytes;
    wr(2'd1, 8'hF0);
    waitPend("R8");
    wr(2'd3, 8'h07); wr(2'd0, 8'hA0);
    waitPend("R8");
    check("R8 reg byte", byteLog[idx + 1], 8'h07);
    s0 = starts; t0 = stops;
    wr(2'd3, 8'hA5); wr(2'd1, 8'hB0); wr(2'd0, 8'hA0);
    waitPend("R8");
    check("R8 restart", starts, s0 + 1);
    check("R8 no stop", stops, t0);
    check("R8 addr", byteLog[idx + 2], 8'hA5);
    wr(2'd0, 8'hA0);
    waitPend("R7");
    rd(2'd3, v); check("R7 rx byte1", v, 8'h96);
    check("R7 master ack", ackLog[idx + 3], 0);
    wr(2'd0, 8'h20);
    waitPend("R7");
    rd(2'd3, v); check("R7 rx byte2", v, 8'h2D);
    check("R7 master nack", ackLog[idx + 4], 1);
    check("R5 irq rx", irq, 1);
    wr(2'd1, 8'h90); wr(2'd0, 8'h20);
    waitIdle("R9");
    check("R9 stop after read", stops, t0 + 1);

    // R12 no stray START/STOP conditions over the whole run
    check("R12 start total", starts, 21);
    check("R12 stop total", stops, 20);
    report();
  end
endmodule